// File: doc/BRIEF.md
# Selectable-Length Burst Bit Scrambler

This block whitens the payload of a burst transmitter one bit at a time. Each payload bit is XORed with the last stage of a linear-feedback shift register. At run time the register can be 15 stages, 6 stages, or switched off so that bits pass through unchanged. The starting state comes from two configuration bytes and is reloaded on the first bit of every packet. The input marks that first bit with a start-of-packet flag. Every packet of a given configuration therefore carries the same whitening sequence.

The block also contains a one-entry stand-in for the block error-correction encoder. This stand-in only registers the bit and its start flag. A placement bit decides the order of the two stages. In one setting the scrambler comes first and the encoder stage second. In the other, bits go through the encoder stage first and are scrambled on the way out. Both ends use a valid/ready handshake. The shift register advances only when a bit actually moves through the scrambler position.

Top module: `burst_scrambler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid` is 0. With the pipeline empty, `inReady` is 1.
- R2: Length code 2'b01 selects 15-stage mode. The seed is {`cfgSeedHi[6:0]`, `cfgSeedLo[7:0]`}, with `cfgSeedHi[6]` as stage 15. Each output bit is the data bit XOR stage 15. The register then shifts toward stage 15, and stage 1 takes stage 15 XOR stage 14 (x^15 + x^14 + 1).
- R3: Length code 2'b00 selects 6-stage mode. The seed is `cfgSeedHi[7:2]`, with bit 7 as stage 6. Feedback is stage 6 XOR stage 5 (x^6 + x^5 + 1). `cfgSeedLo` and `cfgSeedHi[1:0]` have no effect in this mode.
- R4: Length codes 2'b10 and 2'b11 both pass every bit unchanged.
- R5: The bit flagged by `inSop` is scrambled with the freshly loaded seed. Two packets with the same configuration and data therefore produce identical output.
- R6: Length code and seed are sampled only when a start-flagged bit passes the scrambler position. Changes in the middle of a packet affect only the following packet.
- R7: Bits leave in the order they were accepted, each exactly once. Input or output stalls neither skip nor repeat a sequence step. `inReady` is 1 whenever the encoder stage is empty.
- R8: With `cfgPlaceBefore` = 1, bits are scrambled on input acceptance and then registered. With 0, they are registered first and scrambled as they leave. In both orders an accepted bit is presented at the output on the following cycle.
- R9: A start-flagged bit whose requested placement differs from the current one is held off (`inReady` = 0) while the encoder stage holds a bit. It is accepted once the stage is empty.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outSop` stays stable on the next cycle. `outBit` also stays stable when the waiting bit is not start-flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLenSel | input | 2 | Register length code: 00 six-stage, 01 fifteen-stage, 1x off |
| cfgPlaceBefore | input | 1 | 1: scramble before the encoder stage, 0: after it |
| cfgSeedLo | input | 8 | Low seed byte (15-stage mode only) |
| cfgSeedHi | input | 8 | High seed byte: [6:0] upper 15-stage seed, [7:2] 6-stage seed |
| inValid | input | 1 | Input bit valid |
| inReady | output | 1 | Input bit accepted when high with `inValid` |
| inBit | input | 1 | Payload bit |
| inSop | input | 1 | Marks the first bit of a packet |
| outValid | output | 1 | Output bit valid |
| outReady | input | 1 | Downstream accepts the output bit |
| outBit | output | 1 | Scrambled (or passed) bit |
| outSop | output | 1 | Start flag travelling with the bit |

## Verification
The properties check the handshake rules on every cycle. These are the empty-after-reset state, the one-cycle forward latency in both stage orders, readiness when the stage is empty, hold-off of a placement change against a full stage, and output stability under back-pressure. Only the bench's scenarios can show the whitening content itself. That means the two polynomials and their seed layouts, the two off codes, reload on each start bit, mid-packet configuration changes being deferred, and the sequence staying in step under random stalls on both sides. Each of these is judged against a behavioural reference model on every clock.

// File: rtl/bscr_pkg.sv
`timescale 1ns/1ps
package bscr_pkg;
  localparam int LONG_LEN_D  = 15;
  localparam int SHORT_LEN_D = 6;
  localparam int BYTE_W_D    = 8;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_LONG  = 2'b01,
    LEN_OFF_A = 2'b10,
    LEN_OFF_B = 2'b11
  } lenSel_e;

  // strobes from control to the shift-register datapath
  typedef struct packed {
    logic load;      // start bit at the scrambler: take seed this cycle
    logic advance;   // a bit moves through while active: shift
    logic active;    // scrambling enabled for this bit
    logic longMode;  // 15-stage when 1, 6-stage when 0
  } scrStrobe_t;
endpackage

// File: rtl/bscr_fec_stage.sv
`timescale 1ns/1ps
module bscr_fec_stage #(
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [DATA_W-1:0] dnData
);
  logic              fullQ;
  logic [DATA_W-1:0] dataQ;

  assign upReady = !fullQ || dnReady;
  assign dnValid = fullQ;
  assign dnData  = dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      dataQ <= '0;
    end else if (upReady) begin
      fullQ <= upValid;
      if (upValid) dataQ <= upData;
    end
  end
endmodule

// File: rtl/bscr_ctrl.sv
`timescale 1ns/1ps
module bscr_ctrl
  import bscr_pkg::*;
#(
  parameter int LONG_LEN  = LONG_LEN_D,
  parameter int SHORT_LEN = SHORT_LEN_D,
  parameter int BYTE_W    = BYTE_W_D
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgLenSel,
  input  logic                cfgPlaceBefore,
  input  logic [BYTE_W-1:0]   cfgSeedLo,
  input  logic [BYTE_W-1:0]   cfgSeedHi,
  input  logic                inValid,
  input  logic                inSop,
  input  logic                stageFull,
  input  logic                scrValid,
  input  logic                scrReady,
  input  logic                scrSop,
  output logic                holdIn,
  output logic                placeEff,
  output logic                placeQ,
  output scrStrobe_t          strobe,
  output logic [LONG_LEN-1:0] seedWord
);
  localparam int HI_W = LONG_LEN - BYTE_W;

  logic cfgOff, cfgLong, scrFire, sopFire;
  logic activeQ, longQ;
  logic [LONG_LEN-1:0] seedLong, seedShort;

  assign cfgOff  = cfgLenSel[1];
  assign cfgLong = (cfgLenSel == LEN_LONG);

  // placement may switch only on a start bit meeting an empty stage
  assign holdIn   = inValid && inSop && (cfgPlaceBefore != placeQ) && stageFull;
  assign placeEff = (inValid && inSop && !stageFull) ? cfgPlaceBefore : placeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) placeQ <= 1'b0;
    else       placeQ <= placeEff;
  end

  assign scrFire = scrValid && scrReady;
  assign sopFire = scrFire && scrSop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      longQ   <= 1'b0;
    end else if (sopFire) begin
      activeQ <= !cfgOff;
      longQ   <= cfgLong;
    end
  end

  always_comb begin
    strobe.load     = sopFire;
    strobe.active   = sopFire ? !cfgOff : activeQ;
    strobe.longMode = sopFire ? cfgLong : longQ;
    strobe.advance  = scrFire && strobe.active;
  end

  assign seedLong  = {cfgSeedHi[HI_W-1:0], cfgSeedLo};
  assign seedShort = {{(LONG_LEN-SHORT_LEN){1'b0}}, cfgSeedHi[BYTE_W-1 -: SHORT_LEN]};
  assign seedWord  = cfgLong ? seedLong : seedShort;
endmodule

// File: rtl/bscr_lfsr_dp.sv
`timescale 1ns/1ps
module bscr_lfsr_dp
  import bscr_pkg::*;
#(
  parameter int LONG_LEN  = LONG_LEN_D,
  parameter int SHORT_LEN = SHORT_LEN_D
) (
  input  logic                clk,
  input  logic                rstN,
  input  scrStrobe_t          strobe,
  input  logic [LONG_LEN-1:0] seedWord,
  input  logic                dIn,
  output logic                dOut
);
  logic [LONG_LEN-1:0] stateQ, cur, nextState;
  logic lastTap, prevTap, fb;

  assign cur     = strobe.load ? seedWord : stateQ;
  assign lastTap = strobe.longMode ? cur[LONG_LEN-1] : cur[SHORT_LEN-1];
  assign prevTap = strobe.longMode ? cur[LONG_LEN-2] : cur[SHORT_LEN-2];
  assign fb      = lastTap ^ prevTap;

  assign nextState[0] = fb;
  for (genvar g = 1; g < LONG_LEN; g++) begin : g_shift
    if (g < SHORT_LEN) begin : g_common
      assign nextState[g] = cur[g-1];
    end else begin : g_longOnly
      assign nextState[g] = strobe.longMode ? cur[g-1] : 1'b0;
    end
  end

  assign dOut = dIn ^ (strobe.active & lastTap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stateQ <= '0;
    else if (strobe.advance) stateQ <= nextState;
  end
endmodule

// File: rtl/burst_scrambler.sv
`timescale 1ns/1ps
module burst_scrambler #(
  parameter int LONG_LEN  = 15,
  parameter int SHORT_LEN = 6,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgLenSel,
  input  logic              cfgPlaceBefore,
  input  logic [BYTE_W-1:0] cfgSeedLo,
  input  logic [BYTE_W-1:0] cfgSeedHi,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inBit,
  input  logic              inSop,
  output logic              outValid,
  input  logic              outReady,
  output logic              outBit,
  output logic              outSop
);
  import bscr_pkg::*;

  localparam int BEAT_W = 2;  // {bit, start flag}

  logic holdIn, placeEff, placeQ, inValidG;
  logic scrValid, scrReady, scrSop, scrBitIn, scrBitOut;
  logic fecUpValid, fecUpReady, fecDnValid, fecDnReady;
  logic [BEAT_W-1:0] fecUpData, fecDnData;
  logic [LONG_LEN-1:0] seedWord;
  scrStrobe_t strobe;

  assign inValidG = inValid && !holdIn;
  assign inReady  = fecUpReady && !holdIn;

  always_comb begin
    if (placeEff) begin
      scrValid   = inValidG;
      scrBitIn   = inBit;
      scrSop     = inSop;
      scrReady   = fecUpReady;
      fecUpValid = inValidG;
      fecUpData  = {scrBitOut, inSop};
      fecDnReady = outReady;
      outValid   = fecDnValid;
      outBit     = fecDnData[1];
      outSop     = fecDnData[0];
    end else begin
      fecUpValid = inValidG;
      fecUpData  = {inBit, inSop};
      scrValid   = fecDnValid;
      scrBitIn   = fecDnData[1];
      scrSop     = fecDnData[0];
      scrReady   = outReady;
      fecDnReady = outReady;
      outValid   = fecDnValid;
      outBit     = scrBitOut;
      outSop     = fecDnData[0];
    end
  end

  bscr_ctrl #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgLenSel(cfgLenSel), .cfgPlaceBefore(cfgPlaceBefore),
    .cfgSeedLo(cfgSeedLo), .cfgSeedHi(cfgSeedHi), .inValid(inValid), .inSop(inSop),
    .stageFull(fecDnValid), .scrValid(scrValid), .scrReady(scrReady), .scrSop(scrSop),
    .holdIn(holdIn), .placeEff(placeEff), .placeQ(placeQ), .strobe(strobe),
    .seedWord(seedWord)
  );

  bscr_lfsr_dp #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .seedWord(seedWord),
    .dIn(scrBitIn), .dOut(scrBitOut)
  );

  bscr_fec_stage #(.DATA_W(BEAT_W)) uFec (
    .clk(clk), .rstN(rstN), .upValid(fecUpValid), .upReady(fecUpReady),
    .upData(fecUpData), .dnValid(fecDnValid), .dnReady(fecDnReady), .dnData(fecDnData)
  );
endmodule

// File: rtl/bscr_checker.sv
`timescale 1ns/1ps
module bscr_checker (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic inSop,
  input logic cfgPlaceBefore,
  input logic placeQ,
  input logic outValid,
  input logic outReady,
  input logic outBit,
  input logic outSop
);
  p_reset_empty_r1: assert property (@(posedge clk) !rstN |=> !outValid);

  p_forward_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  p_ready_when_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  p_place_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inSop && (cfgPlaceBefore != placeQ) && outValid |-> !inReady);

  p_hold_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSop));

  p_hold_bit_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !outSop |=> $stable(outBit));
endmodule

bind burst_scrambler bscr_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSop(inSop),
  .cfgPlaceBefore(cfgPlaceBefore), .placeQ(placeQ), .outValid(outValid),
  .outReady(outReady), .outBit(outBit), .outSop(outSop)
);

// File: tb/burst_scrambler_test.sv
`timescale 1ns/1ps
module burst_scrambler_test;
  logic clk = 1'b0;
  logic rstN;
  logic [1:0] cfgLenSel;
  logic cfgPlaceBefore;
  logic [7:0] cfgSeedLo, cfgSeedHi;
  logic inValid, inReady, inBit, inSop;
  logic outValid, outReady, outBit, outSop;

  always #2.5 clk = ~clk;

  burst_scrambler uut (
    .clk(clk), .rstN(rstN), .cfgLenSel(cfgLenSel), .cfgPlaceBefore(cfgPlaceBefore),
    .cfgSeedLo(cfgSeedLo), .cfgSeedHi(cfgSeedHi), .inValid(inValid), .inReady(inReady),
    .inBit(inBit), .inSop(inSop), .outValid(outValid), .outReady(outReady),
    .outBit(outBit), .outSop(outSop)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  typedef struct { bit b; bit s; } beat_t;
  beat_t q[$];
  int mState = 0;
  bit mActive = 0, mLong = 0, mPlace = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit modelScramble(bit b, bit s);
    int n;
    bit tap, prev, e;
    if (s) begin
      mActive = (cfgLenSel[1] == 1'b0);
      mLong   = (cfgLenSel == 2'b01);
      mState  = mLong ? int'({cfgSeedHi[6:0], cfgSeedLo}) : int'(cfgSeedHi[7:2]);
    end
    n    = mLong ? 15 : 6;
    tap  = bit'((mState >> (n-1)) & 1);
    prev = bit'((mState >> (n-2)) & 1);
    e    = b ^ (mActive & tap);
    if (mActive) mState = ((mState << 1) | int'(tap ^ prev)) & ((1 << n) - 1);
    return e;
  endfunction

  task automatic step(bit v, bit b, bit s, bit ordy, output bit acc);
    bit full, expRdy;
    beat_t nb;
    @(negedge clk);
    inValid = v; inBit = b; inSop = s; outReady = ordy;
    #1;
    full = (q.size() > 0);
    check({tag, " outValid"}, int'(outValid), int'(full));
    expRdy = (!full || ordy) && !(v && s && (cfgPlaceBefore != mPlace) && full);
    check({tag, " inReady"}, int'(inReady), int'(expRdy));
    if (outValid && ordy && full) begin
      check({tag, " outBit"}, int'(outBit), int'(q[0].b));
      check({tag, " outSop"}, int'(outSop), int'(q[0].s));
      void'(q.pop_front());
    end
    acc = v && inReady;
    if (acc) begin
      if (s) mPlace = cfgPlaceBefore;
      nb.s = s;
      nb.b = modelScramble(b, s);
      q.push_back(nb);
    end
  endtask

  // one packet; pcts are stall percentages; chgAt<0 means no mid-packet change
  task automatic sendPacket(int len, int inStall, int outStall, int chgAt, int dseed);
    bit acc;
    int i = 0;
    while (i < len) begin
      bit v, ordy, b;
      if (i == chgAt) begin
        cfgLenSel = cfgLenSel ^ 2'b01;
        cfgSeedLo = ~cfgSeedLo;
        cfgSeedHi = ~cfgSeedHi;
      end
      v    = ($urandom % 100) >= inStall;
      ordy = ($urandom % 100) >= outStall;
      b    = bit'(((dseed * 7 + i * 13) ^ (i >> 2)) & 1);
      step(v, b, i == 0, ordy, acc);
      if (acc) i++;
    end
  endtask

  task automatic drain();
    bit acc;
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, 1'b1, acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    rstN = 1'b0; inValid = 0; inBit = 0; inSop = 0; outReady = 1;
    cfgLenSel = 2'b01; cfgPlaceBefore = 1'b1; cfgSeedLo = 8'hA5; cfgSeedHi = 8'h3C;
    repeat (3) @(negedge clk);
    #1;
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 inReady in reset", int'(inReady), 1);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 outValid after reset", int'(outValid), 0);

    // R2: fifteen-stage mode, scramble before the stage
    tag = "R2"; sendPacket(40, 0, 0, -1, 1); drain();
    // R5: same packet again must reload the same seed
    tag = "R5"; sendPacket(40, 0, 0, -1, 1); drain();
    tag = "R2"; cfgSeedLo = 8'h01; cfgSeedHi = 8'h80; sendPacket(30, 0, 0, -1, 2); drain();

    // R3: six-stage mode; low byte and hi[1:0] vary but must not matter
    tag = "R3"; cfgLenSel = 2'b00; cfgSeedHi = 8'hB4; cfgSeedLo = 8'h00;
    sendPacket(25, 0, 0, -1, 3); drain();
    cfgSeedHi = 8'hB7; cfgSeedLo = 8'hFF; sendPacket(25, 0, 0, -1, 3); drain();

    // R4: both off codes pass data through
    tag = "R4"; cfgLenSel = 2'b10; sendPacket(20, 0, 0, -1, 4); drain();
    cfgLenSel = 2'b11; sendPacket(20, 0, 0, -1, 5); drain();

    // R6: configuration flipped mid-packet, effective only next packet
    tag = "R6"; cfgLenSel = 2'b01; cfgSeedLo = 8'h5A; cfgSeedHi = 8'h11;
    sendPacket(30, 0, 0, 12, 6); sendPacket(20, 0, 0, -1, 7); drain();

    // R7: random stalls on both sides, both lengths
    tag = "R7"; cfgLenSel = 2'b01; sendPacket(60, 30, 30, -1, 8);
    cfgLenSel = 2'b00; sendPacket(60, 40, 20, -1, 9); drain();

    // R8: scramble after the stage, with and without stalls
    tag = "R8"; cfgPlaceBefore = 1'b0; cfgLenSel = 2'b01; cfgSeedLo = 8'hC3; cfgSeedHi = 8'h66;
    sendPacket(40, 0, 0, -1, 10); sendPacket(40, 25, 35, -1, 11);
    cfgLenSel = 2'b00; sendPacket(30, 20, 20, -1, 12); drain();

    // R9: placement change requested while the stage holds a bit
    tag = "R9"; cfgLenSel = 2'b01;
    step(1'b1, 1'b1, 1'b1, 1'b1, acc);
    step(1'b1, 1'b0, 1'b0, 1'b1, acc);
    step(1'b1, 1'b1, 1'b0, 1'b0, acc);
    cfgPlaceBefore = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b0, acc);
    check("R9 held while full", int'(acc), 0);
    step(1'b1, 1'b1, 1'b1, 1'b0, acc);
    check("R9 still held", int'(acc), 0);
    step(1'b1, 1'b1, 1'b1, 1'b1, acc);
    check("R9 held during drain", int'(acc), 0);
    step(1'b1, 1'b1, 1'b1, 1'b1, acc);
    check("R9 accepted when empty", int'(acc), 1);
    sendPacket(20, 10, 10, -1, 13); drain();

    // R10: long output back-pressure, bench compares on release
    tag = "R10"; sendPacket(30, 0, 60, -1, 14); drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule